// File: doc/BRIEF.md
# Trigger-Matching Hit Filter for a TDC Channel Group

This block sits behind a group of multihit TDC channels that share one hit store. A free-running coarse counter runs inside the block. Each accepted hit is stamped with the counter value of the cycle in which it is presented, together with its channel number. Hits wait in a circular store until a trigger decision can reach back to them. A trigger is stamped the same way when it arrives.

Each trigger selects the stored hits whose stamps fall inside a window. The window opens `LAT` counts before the trigger stamp and stays open for `WIN` counts. Triggers wait in a queue. Because each trigger scans the whole store, windows of nearby triggers may overlap, and a hit can be reported once for each trigger that covers it. The result is a stream of tagged words on a parallel bus: one word per matched hit, then one trailer word per trigger.

A hit is thrown away once it is too old for any trigger that could still arrive. This keeps store slots free during long gaps between triggers. When the trigger queue is full, an arriving trigger is refused and a sticky overflow flag is raised.

Top module: `tdc_trig_filter`

## Requirements
- R1: After reset, `out_vld` and `trg_ovf` are 0, and the first accepted trigger is numbered 0.
- R2: Each hit and each trigger takes the coarse count of the cycle it is sampled in. Let rel = hit_ts − (trg_ts − LAT), taken modulo 2^TS_W. A hit matches a trigger when rel < WIN, and the hit word carries rel. With the defaults (LAT=40, WIN=16), a hit sampled d cycles before the trigger matches for 25 ≤ d ≤ 40, and rel = 40 − d.
- R3: Layout of `out_word` with the defaults:
  - bit 26 is the kind: 0 for a hit word, 1 for a trailer.
  - bits 25:18 hold the trigger number.
  - bits 17:16 hold the channel (0 in a trailer).
  - bits 15:0 hold rel for a hit word, or the hit count for a trailer.
- R4: For each trigger, the matched hits are emitted in arrival order, followed by exactly one trailer. The trailer count equals the number of hit words emitted for that trigger. If no hit matches, only the trailer is emitted.
- R5: Several hits on the same channel that all fall in one window are all reported.
- R6: A hit that lies inside the windows of two triggers is reported under both trigger numbers.
- R7: Triggers are served in arrival order. Only accepted triggers are numbered, and they are numbered consecutively.
- R8: The trigger queue holds TRG_DEPTH (16) entries. A trigger that arrives while the queue is full is refused and never gets a trailer. `trg_ovf` rises in the following cycle and stays at 1 until reset.
- R9: The hit store holds HIT_DEPTH (16) entries. A hit that arrives while the store is full is lost.
- R10: While no trigger is pending, a stored hit whose age exceeds LAT counts is removed, one per cycle, and its slot is freed for later hits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; also advances the coarse counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_vld | input | 1 | A hit is presented this cycle |
| hit_ch | input | CH_W (2) | Channel of the presented hit |
| trg_vld | input | 1 | A trigger is presented this cycle |
| out_vld | output | 1 | `out_word` is valid this cycle |
| out_word | output | OUT_W (27) | Tagged hit word or trailer word |
| trg_ovf | output | 1 | Sticky flag: a trigger was refused |

## Verification
The assertions assume the following about the inputs:
- WIN ≤ LAT, so a window has closed by the time its trigger is sampled.
- At most one hit arrives per cycle.
- No stored hit or pending trigger grows older than 2^TS_W counts, which keeps the modular age arithmetic unambiguous.

Under those conditions the assertions check that:
- hit words stay inside the window;
- trigger numbers on hit and trailer words advance by one per trigger;
- the overflow flag rises only after a trigger and never falls.

The stimulus stays within these limits. It leaves 60 idle cycles after each trigger, so queued triggers drain and aged hits are purged before the next case. Trigger bursts are applied only with an empty hit store.

// File: rtl/tdcf_pkg.sv
package tdcf_pkg;

    // Scan engine phase
    typedef enum logic {
        SC_IDLE = 1'b0,
        SC_SCAN = 1'b1
    } scan_e;

    // Output word kind bit
    localparam logic KIND_HIT = 1'b0;
    localparam logic KIND_TRL = 1'b1;

endpackage

// File: rtl/tdcf_hit_store.sv
module tdcf_hit_store #(
    parameter int DEPTH = 16,
    parameter int TS_W  = 16,
    parameter int CH_W  = 2,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [CH_W-1:0] wr_ch,
    input  logic [TS_W-1:0] wr_ts,
    input  logic            drop,
    input  logic [AW-1:0]   scan_idx,
    output logic [PW-1:0]   rd_ptr,
    output logic [PW-1:0]   wr_ptr,
    output logic            empty,
    output logic [TS_W-1:0] head_ts,
    output logic [TS_W-1:0] scan_ts,
    output logic [CH_W-1:0] scan_ch
);

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
    } ptr_t;

    ptr_t            p_d, p_q;
    logic            full;
    logic            do_wr;
    logic [TS_W-1:0] ts_mem [DEPTH];
    logic [CH_W-1:0] ch_mem [DEPTH];

    always_comb begin
        full  = (p_q.wr[AW] != p_q.rd[AW]) && (p_q.wr[AW-1:0] == p_q.rd[AW-1:0]);
        empty = (p_q.wr == p_q.rd);
        do_wr = wr_en && !full;
        p_d   = p_q;
        if (do_wr)          p_d.wr = p_q.wr + 1'b1;
        if (drop && !empty) p_d.rd = p_q.rd + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    // Payload storage carries no reset; pointers define validity
    always_ff @(posedge clk) begin
        if (do_wr) begin
            ts_mem[p_q.wr[AW-1:0]] <= wr_ts;
            ch_mem[p_q.wr[AW-1:0]] <= wr_ch;
        end
    end

    assign rd_ptr  = p_q.rd;
    assign wr_ptr  = p_q.wr;
    assign head_ts = ts_mem[p_q.rd[AW-1:0]];
    assign scan_ts = ts_mem[scan_idx];
    assign scan_ch = ch_mem[scan_idx];

endmodule

// File: rtl/tdcf_trig_fifo.sv
module tdcf_trig_fifo #(
    parameter int DEPTH  = 16,
    parameter int TS_W   = 16,
    parameter int TNUM_W = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [TS_W-1:0]   push_ts,
    input  logic              pop,
    output logic              full,
    output logic              empty,
    output logic [TS_W-1:0]   head_ts,
    output logic [TNUM_W-1:0] head_num
);

    typedef struct packed {
        logic [PW-1:0]     wr;
        logic [PW-1:0]     rd;
        logic [TNUM_W-1:0] num;
    } tq_t;

    tq_t               q_d, q_q;
    logic              do_push;
    logic [TS_W-1:0]   ts_mem  [DEPTH];
    logic [TNUM_W-1:0] num_mem [DEPTH];

    always_comb begin
        full    = (q_q.wr[AW] != q_q.rd[AW]) && (q_q.wr[AW-1:0] == q_q.rd[AW-1:0]);
        empty   = (q_q.wr == q_q.rd);
        do_push = push && !full;
        q_d     = q_q;
        if (do_push) begin
            q_d.wr  = q_q.wr + 1'b1;
            q_d.num = q_q.num + 1'b1;
        end
        if (pop && !empty) q_d.rd = q_q.rd + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            ts_mem[q_q.wr[AW-1:0]]  <= push_ts;
            num_mem[q_q.wr[AW-1:0]] <= q_q.num;
        end
    end

    assign head_ts  = ts_mem[q_q.rd[AW-1:0]];
    assign head_num = num_mem[q_q.rd[AW-1:0]];

endmodule

// File: rtl/tdc_trig_filter.sv
module tdc_trig_filter
    import tdcf_pkg::*;
#(
    parameter int NCH       = 4,
    parameter int TS_W      = 16,
    parameter int LAT       = 40,
    parameter int WIN       = 16,
    parameter int HIT_DEPTH = 16,
    parameter int TRG_DEPTH = 16,
    parameter int TNUM_W    = 8,
    localparam int CH_W     = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int OUT_W    = 1 + TNUM_W + CH_W + TS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_vld,
    input  logic [CH_W-1:0]  hit_ch,
    input  logic             trg_vld,
    output logic             out_vld,
    output logic [OUT_W-1:0] out_word,
    output logic             trg_ovf
);

    localparam int HAW = $clog2(HIT_DEPTH);
    localparam int HPW = HAW + 1;

    typedef struct packed {
        scan_e            st;
        logic [TS_W-1:0]  tick;
        logic [HPW-1:0]   scan;
        logic [HPW-1:0]   stop;
        logic [TS_W-1:0]  nhit;
        logic             ovf;
        logic             ovld;
        logic [OUT_W-1:0] oword;
    } st_t;

    st_t s_d, s_q;

    logic [HPW-1:0]    hs_rd_ptr, hs_wr_ptr;
    logic              hs_empty;
    logic [TS_W-1:0]   hs_head_ts, hs_scan_ts;
    logic [CH_W-1:0]   hs_scan_ch;
    logic              tq_full, tq_empty, tq_pop;
    logic [TS_W-1:0]   tq_head_ts;
    logic [TNUM_W-1:0] tq_head_num;
    logic              drop;
    logic [TS_W-1:0]   hit_age, win_base, rel;

    tdcf_hit_store #(
        .DEPTH (HIT_DEPTH),
        .TS_W  (TS_W),
        .CH_W  (CH_W)
    ) u_hits (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (hit_vld),
        .wr_ch    (hit_ch),
        .wr_ts    (s_q.tick),
        .drop     (drop),
        .scan_idx (s_q.scan[HAW-1:0]),
        .rd_ptr   (hs_rd_ptr),
        .wr_ptr   (hs_wr_ptr),
        .empty    (hs_empty),
        .head_ts  (hs_head_ts),
        .scan_ts  (hs_scan_ts),
        .scan_ch  (hs_scan_ch)
    );

    tdcf_trig_fifo #(
        .DEPTH  (TRG_DEPTH),
        .TS_W   (TS_W),
        .TNUM_W (TNUM_W)
    ) u_trigs (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (trg_vld),
        .push_ts  (s_q.tick),
        .pop      (tq_pop),
        .full     (tq_full),
        .empty    (tq_empty),
        .head_ts  (tq_head_ts),
        .head_num (tq_head_num)
    );

    always_comb begin
        s_d      = s_q;
        s_d.tick = s_q.tick + 1'b1;
        s_d.ovld = 1'b0;
        tq_pop   = 1'b0;

        // Oldest hit leaves once no future window can reach it
        hit_age  = s_q.tick - hs_head_ts;
        drop     = (s_q.st == SC_IDLE) && tq_empty && !hs_empty &&
                   (hit_age > TS_W'(LAT));

        // Offset of the scanned hit from the head trigger's window start
        win_base = tq_head_ts - TS_W'(LAT);
        rel      = hs_scan_ts - win_base;

        if (trg_vld && tq_full) s_d.ovf = 1'b1;

        case (s_q.st)
            SC_IDLE: begin
                if (!tq_empty) begin
                    s_d.st   = SC_SCAN;
                    s_d.scan = hs_rd_ptr;
                    s_d.stop = hs_wr_ptr;
                    s_d.nhit = '0;
                end
            end
            SC_SCAN: begin
                if (s_q.scan == s_q.stop) begin
                    s_d.ovld  = 1'b1;
                    s_d.oword = {KIND_TRL, tq_head_num, {CH_W{1'b0}}, s_q.nhit};
                    tq_pop    = 1'b1;
                    s_d.st    = SC_IDLE;
                end else begin
                    s_d.scan = s_q.scan + 1'b1;
                    if (rel < TS_W'(WIN)) begin
                        s_d.ovld  = 1'b1;
                        s_d.oword = {KIND_HIT, tq_head_num, hs_scan_ch, rel};
                        s_d.nhit  = s_q.nhit + 1'b1;
                    end
                end
            end
            default: s_d.st = SC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_vld  = s_q.ovld;
    assign out_word = s_q.oword;
    assign trg_ovf  = s_q.ovf;

endmodule

// File: rtl/tdc_trig_filter_chk.sv
module tdc_trig_filter_chk #(
    parameter int TS_W   = 16,
    parameter int TNUM_W = 8,
    parameter int OUT_W  = 27,
    parameter int WIN    = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trg_vld,
    input logic             out_vld,
    input logic             trg_ovf,
    input logic [OUT_W-1:0] out_word
);

    logic              kind;
    logic [TNUM_W-1:0] tnum;
    logic [TS_W-1:0]   data;
    logic              seen_q;
    logic [TNUM_W-1:0] last_q;

    assign kind = out_word[OUT_W-1];
    assign tnum = out_word[OUT_W-2 -: TNUM_W];
    assign data = out_word[TS_W-1:0];

    // Number of the most recent trailer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            last_q <= '0;
        end else if (out_vld && kind) begin
            seen_q <= 1'b1;
            last_q <= tnum;
        end
    end

    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_vld && !trg_ovf));

    // R2
    win_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && !kind) |-> (data < TS_W'(WIN)));

    // R7
    tnum_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && kind && seen_q) |-> (tnum == TNUM_W'(last_q + 1'b1)));

    // R4
    hit_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && !kind && seen_q) |-> (tnum == TNUM_W'(last_q + 1'b1)));

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trg_ovf |=> trg_ovf);

    // R8
    ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trg_ovf) |-> $past(trg_vld));

endmodule

bind tdc_trig_filter tdc_trig_filter_chk #(
    .TS_W   (TS_W),
    .TNUM_W (TNUM_W),
    .OUT_W  (OUT_W),
    .WIN    (WIN)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .trg_vld  (trg_vld),
    .out_vld  (out_vld),
    .trg_ovf  (trg_ovf),
    .out_word (out_word)
);

// File: tb/tdc_trig_filter_bench.sv
module tdc_trig_filter_bench;

    localparam int OUT_W = 27;
    localparam int NROW  = 8;

    // Row fields: {d[7:0], ch[1:0], in_window, rel[15:0]} with LAT=40, WIN=16
    localparam logic [26:0] ROWS [NROW] = '{
        {8'd40, 2'd1, 1'b1, 16'd0},
        {8'd41, 2'd2, 1'b0, 16'd0},
        {8'd25, 2'd3, 1'b1, 16'd15},
        {8'd24, 2'd0, 1'b0, 16'd0},
        {8'd30, 2'd2, 1'b1, 16'd10},
        {8'd0,  2'd1, 1'b0, 16'd0},
        {8'd32, 2'd3, 1'b1, 16'd8},
        {8'd39, 2'd0, 1'b1, 16'd1}
    };

    logic             clk = 1'b0;
    logic             rst_n;
    logic             hit_vld;
    logic [1:0]       hit_ch;
    logic             trg_vld;
    logic             out_vld;
    logic [OUT_W-1:0] out_word;
    logic             trg_ovf;

    int               n_chk  = 0;
    int               n_fail = 0;
    int               ncap   = 0;
    int               tn     = 0;
    logic [OUT_W-1:0] cap [64];

    always #5 clk = ~clk;

    tdc_trig_filter u_tdc_trig_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_vld  (hit_vld),
        .hit_ch   (hit_ch),
        .trg_vld  (trg_vld),
        .out_vld  (out_vld),
        .out_word (out_word),
        .trg_ovf  (trg_ovf)
    );

    always @(negedge clk) begin
        if (out_vld && ncap < 64) begin
            cap[ncap] = out_word;
            ncap++;
        end
    end

    function automatic logic [OUT_W-1:0] hw(int t, int ch, int rel);
        return {1'b0, 8'(t), 2'(ch), 16'(rel)};
    endfunction

    function automatic logic [OUT_W-1:0] tw(int t, int cnt);
        return {1'b1, 8'(t), 2'b00, 16'(cnt)};
    endfunction

    task automatic check(bit ok, string req, logic [OUT_W-1:0] act, logic [OUT_W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive(logic h, logic [1:0] ch, logic t);
        hit_vld = h;
        hit_ch  = ch;
        trg_vld = t;
        step(1);
        hit_vld = 1'b0;
        trg_vld = 1'b0;
    endtask

    task automatic exp_word(int idx, logic [OUT_W-1:0] w, string req);
        check(ncap > idx && cap[idx] == w, req, (ncap > idx) ? cap[idx] : '0, w);
    endtask

    task automatic exp_cnt(int n, string req);
        check(ncap == n, req, OUT_W'(ncap), OUT_W'(n));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n   = 1'b0;
        hit_vld = 1'b0;
        hit_ch  = 2'd0;
        trg_vld = 1'b0;
        step(3);
        // R1: quiet outputs in reset
        check(!out_vld, "R1 out_vld", OUT_W'(out_vld), '0);
        check(!trg_ovf, "R1 trg_ovf", OUT_W'(trg_ovf), '0);
        rst_n = 1'b1;
        step(2);

        // R2 R3 R4: single hit at distance d before a trigger
        for (int r = 0; r < NROW; r++) begin
            int d;
            d    = int'(ROWS[r][26:19]);
            ncap = 0;
            if (d == 0) begin
                drive(1'b1, ROWS[r][18:17], 1'b1);
            end else begin
                drive(1'b1, ROWS[r][18:17], 1'b0);
                step(d - 1);
                drive(1'b0, 2'd0, 1'b1);
            end
            step(60);
            if (ROWS[r][16]) begin
                exp_cnt(2, "R4 row count");
                exp_word(0, hw(tn, int'(ROWS[r][18:17]), int'(ROWS[r][15:0])), "R2 R3 row hit word");
                exp_word(1, tw(tn, 1), "R4 row trailer");
            end else begin
                exp_cnt(1, "R2 row outside count");
                exp_word(0, tw(tn, 0), "R4 row empty trailer");
            end
            tn++;
        end

        // R6: hit at 10 lies in both windows (triggers at 35 and 45)
        ncap = 0;
        for (int c = 0; c <= 45; c++)
            drive(c == 0 || c == 10, (c == 0) ? 2'd1 : 2'd2, c == 35 || c == 45);
        step(60);
        exp_cnt(5, "R6 count");
        exp_word(0, hw(tn, 1, 5), "R6 first trigger hit a");
        exp_word(1, hw(tn, 2, 15), "R6 first trigger hit b");
        exp_word(2, tw(tn, 2), "R6 first trailer");
        exp_word(3, hw(tn + 1, 2, 5), "R6 shared hit again");
        exp_word(4, tw(tn + 1, 1), "R6 second trailer");
        tn += 2;

        // R5: several hits on one channel in one window
        ncap = 0;
        for (int c = 0; c <= 30; c++)
            drive(c <= 3, (c == 3) ? 2'd0 : 2'd3, c == 30);
        step(60);
        exp_cnt(5, "R5 count");
        for (int k = 0; k < 4; k++)
            exp_word(k, hw(tn, (k == 3) ? 0 : 3, 10 + k), "R5 multihit word");
        exp_word(4, tw(tn, 4), "R5 trailer");
        tn++;

        // R9: 17 hits back to back, the last is lost to a full store
        ncap = 0;
        for (int c = 0; c <= 41; c++)
            drive(c <= 16, 2'(c % 4), c == 41);
        step(60);
        exp_cnt(16, "R9 count");
        for (int c = 1; c <= 15; c++)
            exp_word(c - 1, hw(tn, c % 4, c - 1), "R9 stored hit");
        exp_word(15, tw(tn, 15), "R9 trailer");
        tn++;

        // R10: a full store of aged hits is purged, freeing room
        ncap = 0;
        for (int c = 0; c <= 110; c++)
            drive(c <= 15 || c == 80, (c == 80) ? 2'd2 : 2'd1, c == 110);
        step(60);
        exp_cnt(2, "R10 count");
        exp_word(0, hw(tn, 2, 10), "R10 late hit kept");
        exp_word(1, tw(tn, 1), "R10 trailer");
        tn++;

        // R8 R7 R1: trigger burst after a fresh reset
        rst_n = 1'b0;
        step(2);
        check(!trg_ovf, "R1 ovf cleared", OUT_W'(trg_ovf), '0);
        rst_n = 1'b1;
        step(2);
        ncap = 0;
        for (int c = 0; c < 48; c++)
            drive(1'b0, 2'd0, 1'b1);
        step(150);
        check(trg_ovf, "R8 overflow flag", OUT_W'(trg_ovf), OUT_W'(1));
        check(ncap >= 16 && ncap < 48, "R8 refused triggers", OUT_W'(ncap), OUT_W'(47));
        for (int k = 0; k < ncap; k++)
            exp_word(k, tw(k, 0), "R7 consecutive numbering");
        step(10);
        check(trg_ovf, "R8 overflow sticky", OUT_W'(trg_ovf), OUT_W'(1));

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule